// File: doc/BRIEF.md
# External Memory Chip-Select Bus Controller

This block sits between an internal single-request port and an asynchronous external bus serving SRAM and ROM/Flash devices. The internal side presents a 24-bit byte address, a direction, a size (byte or halfword) and write data. The controller decodes the upper eight address bits against four independently configured areas. It then runs one external access: it drives the address, one active-low chip select, an active-low read or write strobe, the lane enables and the write data. When the access finishes, it returns a one-cycle done pulse together with the read data or an error flag.

Each area carries a base and a mask counted in 64 KB pages, a data-width selector (8 or 16 bits) and a wait count. An access with no waits lasts two clock cycles. The area's wait count lengthens every access to that area. After those waits, the external ready line can stretch the final cycle further. A halfword access to an 8-bit area becomes two byte cycles under one unbroken chip select.

Top module: `ebc_ctrl`

## Requirements
- R1: An access to address A selects area i when (A[23:16] & mask_i) == (base_i & mask_i). It drives `bus_cs_n[i]` low and keeps every other chip select high, so at most one chip select is ever low.
- R2: When several areas match, the lowest-numbered matching area is the only one selected.
- R3: An access that matches no area drives no chip select and no strobe. The done pulse arrives with `rsp_err` high after exactly 2 cycles, whatever the level of `bus_rdy`.
- R4: With `bus_rdy` high, a single byte cycle to an area with wait count W keeps the chip select low for exactly 2+W clock cycles.
- R5: `bus_rdy` is sampled only in the final cycle of a byte cycle, which is the cycle after the W wait cycles. Its level during earlier cycles has no effect. Each low sample in that final cycle adds one cycle.
- R6: During an access, the chip select and address bits [23:1] stay constant. The read strobe stays low for the whole access. `bus_rd_n` and `bus_wr_n` are never low together, and neither is low while all chip selects are high.
- R7: In a write, `bus_wr_n` is low for the first 1+W cycles of each byte cycle and high in the final cycle, so the write strobe rises at least one cycle before the chip select does.
- R8: In a 16-bit area, a halfword access is one cycle with address bit 0 cleared, both lanes carrying data, and `bus_be_n`=00. A byte access uses lane 0 (bits 7:0, `bus_be_n`=10) when A[0]=0 and lane 1 (bits 15:8, `bus_be_n`=01) when A[0]=1. The byte read is returned in `rsp_rdata[7:0]` with the upper byte zero.
- R9: In an 8-bit area, all data moves on bits 7:0 with `bus_be_n`=10. A halfword access is split into two byte cycles at the even address and then the odd address, and the read result is {odd byte, even byte}. The chip select stays low across both byte cycles.
- R10: After reset, all chip selects and strobes are high and `rsp_done` is low. `rsp_done` is a single-cycle pulse in the first cycle with the chip select released, and `rsp_rdata` is valid in that cycle.
- R11: A request presented while an access is in progress is ignored. Neither its address nor its direction affects the running access, and no second access follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Per-area base page, area i in bits [8i+7:8i] |
| cfg_mask | input | 32 | Per-area page mask, area i in bits [8i+7:8i] |
| cfg_wide | input | 4 | Per-area width: 1 = 16-bit, 0 = 8-bit |
| cfg_wait | input | 16 | Per-area wait count, area i in bits [4i+3:4i] |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_addr | input | 24 | Request byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_wdata | input | 16 | Write data, byte in bits 7:0 |
| rsp_done | output | 1 | Access-complete pulse |
| rsp_err | output | 1 | Set with done when no area matched |
| rsp_rdata | output | 16 | Read result |
| bus_addr | output | 24 | External address |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_be_n | output | 2 | Active-low byte-lane enables |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 16 | Read data from the bus |
| bus_rdy | input | 1 | External ready |

## Verification
The hardest case to reach is a split halfword to an 8-bit area in which `bus_rdy` is low at the end of the first byte cycle. The second byte cycle must then restart without releasing the chip select, and the wait count must be reloaded. The bench reaches this by reprogramming one area's width and wait count between runs. It holds ready low for a chosen number of cycles from the start of each access, sweeping that number from zero to past the wait window, so that ready falls both inside the wait cycles (where it must be ignored) and inside the final cycle (where it must stretch the access). A device model in the bench answers every address with a computed byte pattern, and the expected cycle counts and data follow arithmetically from the area settings.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = BYTE_W * LANES;

  typedef enum logic [1:0] {
    S_IDLE,
    S_T1,
    S_WAIT,
    S_T2
  } ebc_state_e;

  // place write data on the lanes for the selected area width and size
  function automatic logic [DATA_W-1:0] lane_data(input logic wide, input logic half,
                                                  input logic [DATA_W-1:0] wd);
    if (!wide) return {{BYTE_W{1'b0}}, wd[BYTE_W-1:0]};
    if (half)  return wd;
    return {wd[BYTE_W-1:0], wd[BYTE_W-1:0]};
  endfunction

  // active-low lane enables
  function automatic logic [LANES-1:0] lane_en_n(input logic wide, input logic half,
                                                 input logic a0);
    if (!wide) return 2'b10;
    if (half)  return 2'b00;
    return a0 ? 2'b01 : 2'b10;
  endfunction

endpackage

// File: rtl/ebc_area_decode.sv
module ebc_area_decode #(
  parameter int N_AREA = 4,
  parameter int PAGE_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic [PAGE_W-1:0]        page,
  input  logic [N_AREA*PAGE_W-1:0] cfg_base,
  input  logic [N_AREA*PAGE_W-1:0] cfg_mask,
  output logic                     hit,
  output logic [SEL_W-1:0]         idx
);

  logic [N_AREA-1:0] match;

  for (genvar g = 0; g < N_AREA; g++) begin : g_area
    assign match[g] = ((page & cfg_mask[g*PAGE_W +: PAGE_W]) ==
                       (cfg_base[g*PAGE_W +: PAGE_W] & cfg_mask[g*PAGE_W +: PAGE_W]));
  end

  // lowest index wins: scan from the top so the last assignment is the lowest
  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = N_AREA - 1; i >= 0; i--) begin
      if (match[i]) idx = SEL_W'(i);
    end
  end

endmodule

// File: rtl/ebc_wait_timer.sv
module ebc_wait_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              tick,
  output logic              is_zero,
  output logic              is_one
);

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign is_zero = (cnt == '0);
  assign is_one  = (cnt == WAIT_W'(1));

endmodule

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 8,
  parameter int N_AREA = 4,
  parameter int WAIT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_AREA*PAGE_W-1:0] cfg_base,
  input  logic [N_AREA*PAGE_W-1:0] cfg_mask,
  input  logic [N_AREA-1:0]        cfg_wide,
  input  logic [N_AREA*WAIT_W-1:0] cfg_wait,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_we,
  input  logic                     req_half,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_done,
  output logic                     rsp_err,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [N_AREA-1:0]        bus_cs_n,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n,
  output logic [LANES-1:0]         bus_be_n,
  output logic [DATA_W-1:0]        bus_dout,
  output logic                     bus_doe,
  input  logic [DATA_W-1:0]        bus_din,
  input  logic                     bus_rdy
);

  localparam int SEL_W = (N_AREA > 1) ? $clog2(N_AREA) : 1;

  ebc_state_e        state;
  logic              hit_q, we_q, half_q, wide_q, second_q;
  logic [WAIT_W-1:0] wait_q;
  logic [BYTE_W-1:0] wdata_hi_q;
  logic [BYTE_W-1:0] rd_lo_q;

  logic              dec_hit;
  logic [SEL_W-1:0]  dec_idx;
  logic              sel_wide;
  logic [WAIT_W-1:0] sel_wait;

  logic              accept, split_go, tmr_load, tmr_zero, tmr_one;
  logic [WAIT_W-1:0] tmr_val;
  logic [DATA_W-1:0] rd_asm;

  ebc_area_decode #(
    .N_AREA(N_AREA),
    .PAGE_W(PAGE_W),
    .SEL_W (SEL_W)
  ) i_decode (
    .page    (req_addr[ADDR_W-1 -: PAGE_W]),
    .cfg_base(cfg_base),
    .cfg_mask(cfg_mask),
    .hit     (dec_hit),
    .idx     (dec_idx)
  );

  assign sel_wide = cfg_wide[dec_idx];
  assign sel_wait = cfg_wait[dec_idx*WAIT_W +: WAIT_W];

  assign accept   = (state == S_IDLE) && req_valid;
  assign split_go = (state == S_T2) && hit_q && bus_rdy && !wide_q && half_q && !second_q;
  assign tmr_load = accept || split_go;
  assign tmr_val  = accept ? sel_wait : wait_q;

  ebc_wait_timer #(.WAIT_W(WAIT_W)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .tick    (state == S_WAIT),
    .is_zero (tmr_zero),
    .is_one  (tmr_one)
  );

  // read result for the cycle that finishes the access
  always_comb begin
    if (wide_q) begin
      if (half_q)           rd_asm = bus_din;
      else if (bus_addr[0]) rd_asm = {{BYTE_W{1'b0}}, bus_din[DATA_W-1:BYTE_W]};
      else                  rd_asm = {{BYTE_W{1'b0}}, bus_din[BYTE_W-1:0]};
    end else begin
      if (half_q) rd_asm = {bus_din[BYTE_W-1:0], rd_lo_q};
      else        rd_asm = {{BYTE_W{1'b0}}, bus_din[BYTE_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      hit_q      <= 1'b0;
      we_q       <= 1'b0;
      half_q     <= 1'b0;
      wide_q     <= 1'b0;
      second_q   <= 1'b0;
      wait_q     <= '0;
      wdata_hi_q <= '0;
      rd_lo_q    <= '0;
      rsp_done   <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
      bus_addr   <= '0;
      bus_cs_n   <= '1;
      bus_rd_n   <= 1'b1;
      bus_wr_n   <= 1'b1;
      bus_be_n   <= '1;
      bus_dout   <= '0;
      bus_doe    <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            hit_q      <= dec_hit;
            we_q       <= req_we;
            half_q     <= req_half;
            wide_q     <= sel_wide;
            second_q   <= 1'b0;
            wait_q     <= sel_wait;
            wdata_hi_q <= req_wdata[DATA_W-1:BYTE_W];
            bus_addr   <= req_half ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
            bus_cs_n   <= dec_hit ? ~(N_AREA'(1) << dec_idx) : '1;
            bus_rd_n   <= !(dec_hit && !req_we);
            bus_wr_n   <= !(dec_hit && req_we);
            bus_doe    <= dec_hit && req_we;
            bus_dout   <= lane_data(sel_wide, req_half, req_wdata);
            bus_be_n   <= dec_hit ? lane_en_n(sel_wide, req_half, req_addr[0]) : '1;
            state      <= S_T1;
          end
        end
        S_T1: begin
          if (!hit_q || tmr_zero) begin
            bus_wr_n <= 1'b1;
            state    <= S_T2;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (tmr_one) begin
            bus_wr_n <= 1'b1;
            state    <= S_T2;
          end
        end
        S_T2: begin
          if (!hit_q) begin
            rsp_done  <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
            state     <= S_IDLE;
          end else if (bus_rdy) begin
            if (split_go) begin
              second_q <= 1'b1;
              rd_lo_q  <= bus_din[BYTE_W-1:0];
              bus_addr <= {bus_addr[ADDR_W-1:1], 1'b1};
              bus_dout <= {{BYTE_W{1'b0}}, wdata_hi_q};
              bus_wr_n <= !we_q;
              state    <= S_T1;
            end else begin
              rsp_done  <= 1'b1;
              rsp_rdata <= we_q ? rsp_rdata : rd_asm;
              bus_cs_n  <= '1;
              bus_rd_n  <= 1'b1;
              bus_wr_n  <= 1'b1;
              bus_doe   <= 1'b0;
              bus_be_n  <= '1;
              state     <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
  parameter int ADDR_W = 24,
  parameter int N_AREA = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N_AREA-1:0] bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic              rsp_done,
  input logic              rsp_err
);

  logic seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n)); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n)); // R6

  AST_STROBE_WITH_CS: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n) |-> !(&bus_cs_n)); // R6

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst || !seen)
    (!(&bus_cs_n) && !(&$past(bus_cs_n)))
      |-> ($stable(bus_cs_n) && bus_addr[ADDR_W-1:1] == $past(bus_addr[ADDR_W-1:1]))); // R6

  AST_WR_BEFORE_CS: assert property (@(posedge clk) disable iff (rst || !seen)
    (!(&$past(bus_cs_n)) && (&bus_cs_n)) |-> $past(bus_wr_n)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R10

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst || !seen)
    (rsp_done && !rsp_err) |-> (!(&$past(bus_cs_n)) && (&bus_cs_n))); // R10

  AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (rst || !seen)
    (rsp_done && rsp_err) |-> (&$past(bus_cs_n))); // R3

endmodule

bind ebc_ctrl ebc_checker #(
  .ADDR_W(ADDR_W),
  .N_AREA(N_AREA)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_addr(bus_addr),
  .bus_cs_n(bus_cs_n),
  .bus_rd_n(bus_rd_n),
  .bus_wr_n(bus_wr_n),
  .rsp_done(rsp_done),
  .rsp_err (rsp_err)
);

// File: tb/test_ebc_ctrl.sv
module test_ebc_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] cfg_base, cfg_mask;
  logic [3:0]  cfg_wide;
  logic [15:0] cfg_wait;
  logic        req_valid, req_we, req_half;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic [23:0] bus_addr;
  logic [3:0]  bus_cs_n;
  logic        bus_rd_n, bus_wr_n, bus_doe;
  logic [1:0]  bus_be_n;
  logic [15:0] bus_dout, bus_din;
  logic        bus_rdy;

  logic [7:0] tb_base [4];
  logic [7:0] tb_mask [4];
  logic       tb_wide [4];
  logic [3:0] tb_wait [4];

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      cfg_base[i*8 +: 8] = tb_base[i];
      cfg_mask[i*8 +: 8] = tb_mask[i];
      cfg_wide[i]        = tb_wide[i];
      cfg_wait[i*4 +: 4] = tb_wait[i];
    end
  end

  ebc_ctrl i_ebc_ctrl (
    .clk(clk), .rst(rst),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_wide(cfg_wide), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we), .req_half(req_half),
    .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_be_n(bus_be_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_rdy(bus_rdy)
  );

  function automatic int area_of(input logic [7:0] pg);
    for (int i = 0; i < 4; i++) begin
      if ((pg & tb_mask[i]) == (tb_base[i] & tb_mask[i])) return i;
    end
    return -1;
  endfunction

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // device model: a 16-bit device shows both bytes of the halfword, an 8-bit one its byte on lane 0
  always_comb begin
    int ar;
    ar = area_of(bus_addr[23:16]);
    if (ar >= 0 && tb_wide[ar[1:0]])
      bus_din = {fbyte({bus_addr[23:1], 1'b1}), fbyte({bus_addr[23:1], 1'b0})};
    else
      bus_din = {8'hEE, fbyte(bus_addr)};
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_access(input logic [23:0] addr, input bit we, input bit half,
                           input logic [15:0] wd, input int k, input bit hold);
    int ar, w, endi, len, idx, cs_cyc, rd_low, wr_low;
    bit wide, split, last_wr, addr_bad, first_a0;
    logic [3:0] cs_seen;
    logic [7:0] wb [2];
    logic [7:0] wbe [2];
    logic [15:0] exp_rd;
    ar    = area_of(addr[23:16]);
    wide  = (ar >= 0) ? tb_wide[ar[1:0]] : 1'b0;
    w     = (ar >= 0) ? int'(tb_wait[ar[1:0]]) : 0;
    split = (ar >= 0) && !wide && half;
    endi  = (k > 1 + w) ? k : 1 + w;
    len   = (ar < 0) ? 2 : (endi + 1 + (split ? 2 + w : 0));
    cs_cyc = 0; rd_low = 0; wr_low = 0; last_wr = 1'b0; addr_bad = 1'b0; first_a0 = 1'b0;
    cs_seen = '0;
    wb[0] = 8'h00; wb[1] = 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_we = we; req_half = half; req_wdata = wd;
    idx = 0;
    forever begin
      @(negedge clk);
      if (!hold) req_valid = 1'b0;
      if (hold && idx == 1) begin
        req_addr = 24'h05_0000;  // R11: altered request while busy
        req_we   = !we;
      end
      if (rsp_done) break;
      if (idx == 0) first_a0 = bus_addr[0];
      if (!(&bus_cs_n)) begin
        cs_cyc++;
        cs_seen = cs_seen | ~bus_cs_n;
        last_wr = bus_wr_n;
        if (bus_addr[23:1] != addr[23:1]) addr_bad = 1'b1;
      end
      if (!bus_rd_n) rd_low++;
      if (!bus_wr_n) begin
        wr_low++;
        if (wide) begin
          if (!bus_be_n[0]) wb[0] = bus_dout[7:0];
          if (!bus_be_n[1]) wb[1] = bus_dout[15:8];
        end else begin
          if (!bus_be_n[0]) wb[bus_addr[0]] = bus_dout[7:0];
          if (!bus_be_n[1]) wb[1] = 8'hFF;
        end
      end
      bus_rdy = (idx >= k);
      idx++;
      if (idx > 200) break;
    end
    if (hold) req_valid = 1'b0;
    // R4 R5: cycle count up to done
    check(idx == len, "R4 R5 length", 32'(idx), 32'(len));
    if (ar < 0) begin
      check(rsp_err == 1'b1, "R3 err flag", 32'(rsp_err), 32'd1);
      check(cs_cyc == 0 && rd_low == 0 && wr_low == 0, "R3 no cs/strobe",
            32'(cs_cyc + rd_low + wr_low), 32'd0);
    end else begin
      check(rsp_err == 1'b0, "R10 no err", 32'(rsp_err), 32'd0);
      check(cs_seen == (4'd1 << ar), "R1 R2 cs select", 32'(cs_seen), 32'(4'd1 << ar));
      check(cs_cyc == len && !addr_bad, "R6 cs/addr held", 32'(cs_cyc), 32'(len));
      if (half) check(first_a0 == 1'b0, "R8 R9 even first", 32'(first_a0), 32'd0);
      wbe[0] = 8'h00; wbe[1] = 8'h00;
      if (we) begin
        check(wr_low == (1 + w) * (split ? 2 : 1) && last_wr == 1'b1, "R7 write strobe",
              32'(wr_low), 32'((1 + w) * (split ? 2 : 1)));
        if (half) begin
          wbe[0] = wd[7:0]; wbe[1] = wd[15:8];
        end else begin
          wbe[addr[0]] = wd[7:0];
        end
        check(wb[0] == wbe[0] && wb[1] == wbe[1], wide ? "R8 write lanes" : "R9 write lanes",
              32'({wb[1], wb[0]}), 32'({wbe[1], wbe[0]}));
      end else begin
        check(rd_low == len && wr_low == 0, "R6 read strobe", 32'(rd_low), 32'(len));
        if (half) exp_rd = {fbyte({addr[23:1], 1'b1}), fbyte({addr[23:1], 1'b0})};
        else      exp_rd = {8'h00, fbyte(addr)};
        check(rsp_rdata == exp_rd, wide ? "R8 read data" : "R9 read data",
              32'(rsp_rdata), 32'(exp_rd));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    tb_base[0] = 8'h10; tb_mask[0] = 8'hF0; tb_wide[0] = 1'b1; tb_wait[0] = 4'd0;
    tb_base[1] = 8'h20; tb_mask[1] = 8'hE0; tb_wide[1] = 1'b0; tb_wait[1] = 4'd1;
    tb_base[2] = 8'h30; tb_mask[2] = 8'hF8; tb_wide[2] = 1'b0; tb_wait[2] = 4'd3;
    tb_base[3] = 8'hC5; tb_mask[3] = 8'hFF; tb_wide[3] = 1'b1; tb_wait[3] = 4'd2;
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_we = 1'b0; req_half = 1'b0;
    req_wdata = '0; bus_rdy = 1'b1;
    repeat (3) @(negedge clk);
    check(&bus_cs_n && bus_rd_n && bus_wr_n, "R10 reset bus idle",
          32'({bus_cs_n, bus_rd_n, bus_wr_n}), 32'h3F);
    check(!rsp_done, "R10 reset done low", 32'(rsp_done), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3: every page, byte read
    for (int pg = 0; pg < 256; pg++) begin
      do_access({pg[7:0], 16'h0034}, 1'b0, 1'b0, 16'h0000, 0, 1'b0);
    end
    // R2: page 0x33 matches areas 1 and 2
    do_access(24'h33_0101, 1'b1, 1'b1, 16'h9A41, 0, 1'b0);
    // R3: unmatched with ready low
    do_access(24'h05_1235, 1'b1, 1'b0, 16'h00C7, 99, 1'b0);
    do_access(24'h7F_0002, 1'b0, 1'b1, 16'h0000, 99, 1'b0);

    // R4 R5 R7 R8 R9: sweep area 3 width, waits, ready delay, size, direction, alignment
    for (int w = 0; w < 4; w++) begin
      for (int wd = 0; wd < 2; wd++) begin
        tb_wait[3] = 4'(w);
        tb_wide[3] = wd[0];
        for (int k = 0; k <= w + 3; k++) begin
          for (int we = 0; we < 2; we++) begin
            for (int hf = 0; hf < 2; hf++) begin
              for (int a0 = 0; a0 < 2; a0++) begin
                do_access({8'hC5, 8'h3C, 7'h2B, a0[0]}, we[0], hf[0],
                          {8'h90 ^ 8'(w * 16 + k), 8'h41 ^ 8'(k)}, k, 1'b0);
              end
            end
          end
        end
      end
    end

    // R11: request held and altered during a busy access
    tb_wait[3] = 4'd2; tb_wide[3] = 1'b0;
    do_access(24'hC5_0010, 1'b0, 1'b1, 16'h0000, 0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(&bus_cs_n && !rsp_done, "R11 no follow-on access",
            32'({bus_cs_n, rsp_done}), 32'h1E);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule